// File: doc/BRIEF.md
# Eight-Pin GPIO Port with Peripheral Pin Overrides

This block controls a general-purpose I/O port of eight pins. Each pin has a direction bit and a data bit, and both are held in registers that a simple bus writes and reads. From these two bits the block derives three signals for each pad: an output enable, an output value and a pull-up enable. The pad levels are captured through a two-flop synchronizer into a pin register that the bus can read.

Two on-chip peripherals can take over the pins. The SPI engine's role changes which pins are forced to be inputs and which ones carry its serial outputs. The four timer compare units can drive the upper four pins. A compare unit reaches its pin only when software has set that pin's direction bit. A pin that the SPI role forces to input still lets its data bit choose the pull-up. The pad cells, the SPI engine and the timers are outside the block and appear only as input signals.

Top module: `gpio_ovr_port`

## Requirements
- R1: While reset is asserted and straight after it, the direction and data registers are 0. Every pin then has padOe=0, padOut=0 and padPullEn=0.
- R2: A pin whose direction bit is 0 has padOe=0 and padOut=0, and its padPullEn equals its data bit. More generally, padOut is 0 on every pin whose padOe is 0.
- R3: A pin whose direction bit is 1, with no override active, has padOe=1, padPullEn=0 and padOut equal to its data bit. padOe and padPullEn are never both 1 on the same pin.
- R4: When spiEn=1 and spiMaster=1, pin 3 has padOe=0 whatever its direction bit says, and its padPullEn equals data bit 3. Pins 1 and 2 follow their direction bits.
- R5: When spiEn=1 and spiMaster=0, pins 1 and 2 have padOe=0 whatever their direction bits say, and their padPullEn equals their data bits. Pin 3 follows its direction bit.
- R6: When spiEn=1 and spiMaster=1, pin 2 drives spiMosiOut and pin 1 drives spiSckOut, each only if it is an output. When spiEn=1 and spiMaster=0, pin 3 drives spiMisoOut if it is an output.
- R7: Compare channel k (k=0..3) maps to pin 4+k. When cmpEn[k]=1 and the direction bit of pin 4+k is 1, that pin drives cmpVal[k]. When the direction bit is 0, the pin stays an input with padOe=0, and its pull-up follows its data bit.
- R8: When cmpEn[k]=0, pin 4+k behaves as a plain GPIO pin and outputs its data bit.
- R9: A read at busAddr=0 returns padIn as it was two clock edges earlier.
- R10: A write at busAddr=1 sets the direction register and a write at busAddr=2 sets the data register. Both take effect at the next clock edge. Reads at those addresses return the register contents, so address 2 returns the written latch value and not the pad level. Address 3 reads 0. Writes to addresses 0 and 3 change nothing.
- R11: When spiEn=0, spiMaster and the SPI output values have no effect on any pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busAddr | input | 2 | Register address: 0 pin, 1 direction, 2 data |
| busWrEn | input | 1 | Write strobe |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Read data for busAddr (combinational) |
| spiEn | input | 1 | SPI engine enabled |
| spiMaster | input | 1 | 1 = SPI master role, 0 = SPI slave role |
| spiMosiOut | input | 1 | Master data output from the SPI engine |
| spiSckOut | input | 1 | Clock output from the SPI engine |
| spiMisoOut | input | 1 | Slave data output from the SPI engine |
| cmpEn | input | 4 | Compare output enable, channel k drives pin 4+k |
| cmpVal | input | 4 | Compare output value per channel |
| padIn | input | 8 | Pad input levels |
| padOe | output | 8 | Pad output enable |
| padOut | output | 8 | Pad output value |
| padPullEn | output | 8 | Pad pull-up enable |

## Verification
The assertions assume that busWrEn, busAddr and busWrData are stable around each rising edge. They also assume that the peripheral inputs only mean something as a level, so a glitch between edges does not matter. The pin-read property assumes that padIn is sampled only at clock edges. The stimulus meets these assumptions by changing every input a fixed delay after the rising edge. Directed phases cover each SPI role, each compare channel and every address, and a long randomized phase then mixes them all.

// File: rtl/gpio_ovr_pkg.sv
package gpio_ovr_pkg;

  localparam logic [1:0] ADDR_PIN  = 2'd0;
  localparam logic [1:0] ADDR_DIR  = 2'd1;
  localparam logic [1:0] ADDR_DATA = 2'd2;

  typedef enum logic [1:0] {
    RD_PIN  = 2'd0,
    RD_DIR  = 2'd1,
    RD_DATA = 2'd2,
    RD_NONE = 2'd3
  } rdSel_e;

  typedef struct packed {
    logic   wrDir;
    logic   wrData;
    rdSel_e rdSel;
  } busStrobe_t;

endpackage

// File: rtl/gpio_ovr_ctrl.sv
module gpio_ovr_ctrl
  import gpio_ovr_pkg::*;
#(
  parameter int NUM_PINS = 8,
  parameter int SCK_PIN  = 1,
  parameter int MOSI_PIN = 2,
  parameter int MISO_PIN = 3
) (
  input  logic [1:0]          busAddr,
  input  logic                busWrEn,
  input  logic                spiEn,
  input  logic                spiMaster,
  output busStrobe_t          strobe,
  output logic [NUM_PINS-1:0] forceInMask,
  output logic [NUM_PINS-1:0] spiDriveMask
);

  localparam logic [NUM_PINS-1:0] ONE = {{(NUM_PINS-1){1'b0}}, 1'b1};
  localparam logic [NUM_PINS-1:0] MASTER_IN  = ONE << MISO_PIN;
  localparam logic [NUM_PINS-1:0] SLAVE_IN   = (ONE << MOSI_PIN) | (ONE << SCK_PIN);
  localparam logic [NUM_PINS-1:0] MASTER_OUT = SLAVE_IN;
  localparam logic [NUM_PINS-1:0] SLAVE_OUT  = MASTER_IN;

  // bus decode
  always_comb begin
    strobe.wrDir  = busWrEn && (busAddr == ADDR_DIR);
    strobe.wrData = busWrEn && (busAddr == ADDR_DATA);
    unique case (busAddr)
      ADDR_PIN:  strobe.rdSel = RD_PIN;
      ADDR_DIR:  strobe.rdSel = RD_DIR;
      ADDR_DATA: strobe.rdSel = RD_DATA;
      default:   strobe.rdSel = RD_NONE;
    endcase
  end

  // SPI role decode: which pins are forced in, which carry engine values
  always_comb begin
    forceInMask  = '0;
    spiDriveMask = '0;
    if (spiEn) begin
      if (spiMaster) begin
        forceInMask  = MASTER_IN;
        spiDriveMask = MASTER_OUT;
      end else begin
        forceInMask  = SLAVE_IN;
        spiDriveMask = SLAVE_OUT;
      end
    end
  end

endmodule

// File: rtl/gpio_ovr_datapath.sv
module gpio_ovr_datapath
  import gpio_ovr_pkg::*;
#(
  parameter int NUM_PINS    = 8,
  parameter int SYNC_STAGES = 2,
  parameter int CMP_BASE    = 4,
  parameter int NUM_CMP     = 4,
  parameter int SCK_PIN     = 1,
  parameter int MOSI_PIN    = 2,
  parameter int MISO_PIN    = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  busStrobe_t          strobe,
  input  logic [NUM_PINS-1:0] busWrData,
  output logic [NUM_PINS-1:0] busRdData,
  input  logic [NUM_PINS-1:0] forceInMask,
  input  logic [NUM_PINS-1:0] spiDriveMask,
  input  logic                spiMosiOut,
  input  logic                spiSckOut,
  input  logic                spiMisoOut,
  input  logic [NUM_CMP-1:0]  cmpEn,
  input  logic [NUM_CMP-1:0]  cmpVal,
  input  logic [NUM_PINS-1:0] padIn,
  output logic [NUM_PINS-1:0] padOe,
  output logic [NUM_PINS-1:0] padOut,
  output logic [NUM_PINS-1:0] padPullEn
);

  localparam int CMP_TOP = CMP_BASE + NUM_CMP;

  logic [NUM_PINS-1:0] dirReg;
  logic [NUM_PINS-1:0] dataReg;
  logic [NUM_PINS-1:0] syncStage [SYNC_STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dirReg  <= '0;
      dataReg <= '0;
    end else begin
      if (strobe.wrDir)  dirReg  <= busWrData;
      if (strobe.wrData) dataReg <= busWrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < SYNC_STAGES; s++) syncStage[s] <= '0;
    end else begin
      syncStage[0] <= padIn;
      for (int s = 1; s < SYNC_STAGES; s++) syncStage[s] <= syncStage[s-1];
    end
  end

  always_comb begin
    unique case (strobe.rdSel)
      RD_PIN:  busRdData = syncStage[SYNC_STAGES-1];
      RD_DIR:  busRdData = dirReg;
      RD_DATA: busRdData = dataReg;
      default: busRdData = '0;
    endcase
  end

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    logic altSel;
    logic altVal;
    logic oeBit;

    if (p >= CMP_BASE && p < CMP_TOP) begin : g_cmp
      assign altSel = cmpEn[p-CMP_BASE];
      assign altVal = cmpVal[p-CMP_BASE];
    end else begin : g_spi
      assign altSel = spiDriveMask[p];
      assign altVal = (p == MOSI_PIN) ? spiMosiOut :
                      (p == SCK_PIN)  ? spiSckOut  : spiMisoOut;
    end

    assign oeBit        = dirReg[p] & ~forceInMask[p];
    assign padOe[p]     = oeBit;
    assign padOut[p]    = oeBit & (altSel ? altVal : dataReg[p]);
    assign padPullEn[p] = ~oeBit & dataReg[p];
  end

endmodule

// File: rtl/gpio_ovr_port.sv
module gpio_ovr_port
  import gpio_ovr_pkg::*;
#(
  parameter int NUM_PINS    = 8,
  parameter int SYNC_STAGES = 2,
  parameter int CMP_BASE    = 4,
  parameter int NUM_CMP     = 4,
  parameter int SCK_PIN     = 1,
  parameter int MOSI_PIN    = 2,
  parameter int MISO_PIN    = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [1:0]          busAddr,
  input  logic                busWrEn,
  input  logic [NUM_PINS-1:0] busWrData,
  output logic [NUM_PINS-1:0] busRdData,
  input  logic                spiEn,
  input  logic                spiMaster,
  input  logic                spiMosiOut,
  input  logic                spiSckOut,
  input  logic                spiMisoOut,
  input  logic [NUM_CMP-1:0]  cmpEn,
  input  logic [NUM_CMP-1:0]  cmpVal,
  input  logic [NUM_PINS-1:0] padIn,
  output logic [NUM_PINS-1:0] padOe,
  output logic [NUM_PINS-1:0] padOut,
  output logic [NUM_PINS-1:0] padPullEn
);

  busStrobe_t          strobe;
  logic [NUM_PINS-1:0] forceInMask;
  logic [NUM_PINS-1:0] spiDriveMask;

  gpio_ovr_ctrl #(
    .NUM_PINS(NUM_PINS), .SCK_PIN(SCK_PIN), .MOSI_PIN(MOSI_PIN), .MISO_PIN(MISO_PIN)
  ) ctrl_i (
    .busAddr(busAddr), .busWrEn(busWrEn), .spiEn(spiEn), .spiMaster(spiMaster),
    .strobe(strobe), .forceInMask(forceInMask), .spiDriveMask(spiDriveMask)
  );

  gpio_ovr_datapath #(
    .NUM_PINS(NUM_PINS), .SYNC_STAGES(SYNC_STAGES), .CMP_BASE(CMP_BASE),
    .NUM_CMP(NUM_CMP), .SCK_PIN(SCK_PIN), .MOSI_PIN(MOSI_PIN), .MISO_PIN(MISO_PIN)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .busWrData(busWrData),
    .busRdData(busRdData), .forceInMask(forceInMask), .spiDriveMask(spiDriveMask),
    .spiMosiOut(spiMosiOut), .spiSckOut(spiSckOut), .spiMisoOut(spiMisoOut),
    .cmpEn(cmpEn), .cmpVal(cmpVal), .padIn(padIn),
    .padOe(padOe), .padOut(padOut), .padPullEn(padPullEn)
  );

endmodule

// File: rtl/gpio_ovr_port_chk.sv
module gpio_ovr_port_chk #(
  parameter int NUM_PINS    = 8,
  parameter int SYNC_STAGES = 2,
  parameter int CMP_BASE    = 4,
  parameter int NUM_CMP     = 4,
  parameter int SCK_PIN     = 1,
  parameter int MOSI_PIN    = 2,
  parameter int MISO_PIN    = 3
) (
  input logic                clk,
  input logic                rstN,
  input logic [1:0]          busAddr,
  input logic                busWrEn,
  input logic [NUM_PINS-1:0] busWrData,
  input logic [NUM_PINS-1:0] busRdData,
  input logic                spiEn,
  input logic                spiMaster,
  input logic                spiMosiOut,
  input logic                spiSckOut,
  input logic                spiMisoOut,
  input logic [NUM_CMP-1:0]  cmpEn,
  input logic [NUM_CMP-1:0]  cmpVal,
  input logic [NUM_PINS-1:0] padIn,
  input logic [NUM_PINS-1:0] padOe,
  input logic [NUM_PINS-1:0] padOut,
  input logic [NUM_PINS-1:0] padPullEn
);

  logic [1:0] sinceRst;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sinceRst <= '0;
    else if (sinceRst != 2'd3) sinceRst <= sinceRst + 2'd1;
  end

  a_r2_idle_low: assert property (@(posedge clk) disable iff (!rstN)
    (padOut & ~padOe) == '0);

  a_r3_oe_pull_excl: assert property (@(posedge clk) disable iff (!rstN)
    (padOe & padPullEn) == '0);

  a_r4_master_miso_in: assert property (@(posedge clk) disable iff (!rstN)
    (spiEn && spiMaster) |-> !padOe[MISO_PIN]);

  a_r5_slave_pins_in: assert property (@(posedge clk) disable iff (!rstN)
    (spiEn && !spiMaster) |-> (!padOe[MOSI_PIN] && !padOe[SCK_PIN]));

  a_r6_mosi_drive: assert property (@(posedge clk) disable iff (!rstN)
    (spiEn && spiMaster && padOe[MOSI_PIN]) |-> (padOut[MOSI_PIN] == spiMosiOut));

  a_r6_sck_drive: assert property (@(posedge clk) disable iff (!rstN)
    (spiEn && spiMaster && padOe[SCK_PIN]) |-> (padOut[SCK_PIN] == spiSckOut));

  a_r6_miso_drive: assert property (@(posedge clk) disable iff (!rstN)
    (spiEn && !spiMaster && padOe[MISO_PIN]) |-> (padOut[MISO_PIN] == spiMisoOut));

  for (genvar k = 0; k < NUM_CMP; k++) begin : g_cmpChk
    a_r7_cmp_drive: assert property (@(posedge clk) disable iff (!rstN)
      (cmpEn[k] && padOe[CMP_BASE+k]) |-> (padOut[CMP_BASE+k] == cmpVal[k]));
  end

  a_r10_data_readback: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst != 2'd0 && $past(busWrEn && busAddr == 2'd2) && busAddr == 2'd2)
      |-> (busRdData == $past(busWrData)));

  if (SYNC_STAGES == 2) begin : g_syncChk
    a_r9_pin_lag: assert property (@(posedge clk) disable iff (!rstN)
      (sinceRst >= 2'd2 && busAddr == 2'd0) |-> (busRdData == $past(padIn, 2)));
  end

endmodule

bind gpio_ovr_port gpio_ovr_port_chk #(
  .NUM_PINS(NUM_PINS), .SYNC_STAGES(SYNC_STAGES), .CMP_BASE(CMP_BASE),
  .NUM_CMP(NUM_CMP), .SCK_PIN(SCK_PIN), .MOSI_PIN(MOSI_PIN), .MISO_PIN(MISO_PIN)
) chk_i (.*);

// File: tb/gpio_ovr_port_tb.sv
module gpio_ovr_port_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] busAddr = '0;
  logic       busWrEn = 1'b0;
  logic [7:0] busWrData = '0;
  logic [7:0] busRdData;
  logic       spiEn = 1'b0, spiMaster = 1'b0;
  logic       spiMosiOut = 1'b0, spiSckOut = 1'b0, spiMisoOut = 1'b0;
  logic [3:0] cmpEn = '0, cmpVal = '0;
  logic [7:0] padIn = '0;
  logic [7:0] padOe, padOut, padPullEn;

  always #10 clk = ~clk;

  gpio_ovr_port dut_i (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData), .spiEn(spiEn),
    .spiMaster(spiMaster), .spiMosiOut(spiMosiOut), .spiSckOut(spiSckOut),
    .spiMisoOut(spiMisoOut), .cmpEn(cmpEn), .cmpVal(cmpVal), .padIn(padIn),
    .padOe(padOe), .padOut(padOut), .padPullEn(padPullEn)
  );

  int    errCount = 0;
  int    chkCount = 0;
  bit    checkOn  = 1'b0;
  bit    finished = 1'b0;
  string curReq   = "R1";

  // reference model state
  logic [7:0] mDir = '0, mData = '0;
  logic [7:0] mSync[$] = '{8'h00, 8'h00};

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mDir = '0; mData = '0;
      mSync = '{8'h00, 8'h00};
    end else begin
      if (busWrEn && busAddr == 2'd1) mDir = busWrData;
      if (busWrEn && busAddr == 2'd2) mData = busWrData;
      mSync.push_back(padIn);
      void'(mSync.pop_front());
    end
  end

  task automatic check(string what, logic [7:0] act, logic [7:0] exp);
    chkCount++;
    if (act !== exp) begin
      errCount++;
      $display("FAIL %s %s: actual=%h expected=%h", curReq, what, act, exp);
    end
  endtask

  task automatic compareAll();
    logic [7:0] eOe, eOut, ePu, eRd;
    for (int i = 0; i < 8; i++) begin
      bit forcedIn = spiEn && ((spiMaster && i == 3) || (!spiMaster && (i == 1 || i == 2)));
      if (mDir[i] && !forcedIn) begin
        logic v;
        v = mData[i];
        if (spiEn && spiMaster && i == 2) v = spiMosiOut;
        if (spiEn && spiMaster && i == 1) v = spiSckOut;
        if (spiEn && !spiMaster && i == 3) v = spiMisoOut;
        if (i >= 4 && cmpEn[i-4]) v = cmpVal[i-4];
        eOe[i] = 1'b1; eOut[i] = v; ePu[i] = 1'b0;
      end else begin
        eOe[i] = 1'b0; eOut[i] = 1'b0; ePu[i] = mData[i];
      end
    end
    case (busAddr)
      2'd0: eRd = mSync[0];
      2'd1: eRd = mDir;
      2'd2: eRd = mData;
      default: eRd = 8'h00;
    endcase
    check("padOe", padOe, eOe);
    check("padOut", padOut, eOut);
    check("padPullEn", padPullEn, ePu);
    check("busRdData", busRdData, eRd);
  endtask

  always @(negedge clk) if (checkOn && !finished) compareAll();

  task automatic tick();
    @(posedge clk);
    #4;
  endtask

  task automatic busWrite(logic [1:0] a, logic [7:0] d);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    tick();
    busWrEn = 1'b0;
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errCount, chkCount);
      $finish;
    end
  endtask

  initial begin
    #(20 * 150000);
    errCount++;
    chkCount++;
    $display("FAIL watchdog: actual=timeout expected=done");
    finish();
  end

  initial begin
    // R1: reset state, while held and after release
    padIn = 8'hFF; busWrData = 8'hFF;
    tick(); checkOn = 1'b1;
    repeat (3) tick();
    rstN = 1'b1;
    tick();
    #6;
    check("reset padOe", padOe, 8'h00);
    check("reset padPullEn", padPullEn, 8'h00);
    check("reset padOut", padOut, 8'h00);
    #4;

    // R10: address map and ignored writes
    curReq = "R10";
    busWrite(2'd1, 8'h00);
    busWrite(2'd2, 8'h5A);
    busWrite(2'd0, 8'hFF);
    busWrite(2'd3, 8'hFF);
    for (int a = 0; a < 4; a++) begin busAddr = a[1:0]; tick(); end

    // R2: inputs with pull-up from data
    curReq = "R2";
    busWrite(2'd2, 8'hA5);
    busAddr = 2'd2; repeat (2) tick();

    // R3: plain outputs
    curReq = "R3";
    busWrite(2'd1, 8'hFF);
    busWrite(2'd2, 8'h3C); tick();
    busWrite(2'd2, 8'hC3); tick();

    // R4 / R6: SPI master
    curReq = "R4";
    spiEn = 1'b1; spiMaster = 1'b1;
    busWrite(2'd1, 8'h0F);
    busWrite(2'd2, 8'h08); tick();
    curReq = "R6";
    for (int j = 0; j < 4; j++) begin
      spiMosiOut = j[0]; spiSckOut = j[1]; spiMisoOut = ~j[0]; tick();
    end

    // R5 / R6: SPI slave
    curReq = "R5";
    spiMaster = 1'b0;
    busWrite(2'd1, 8'h0E);
    busWrite(2'd2, 8'h06); tick();
    curReq = "R6";
    for (int j = 0; j < 4; j++) begin
      spiMisoOut = j[0]; spiMosiOut = j[1]; tick();
    end
    busWrite(2'd1, 8'h06); tick();

    // R11: SPI disabled ignores role and values
    curReq = "R11";
    spiEn = 1'b0;
    busWrite(2'd1, 8'h0E);
    for (int j = 0; j < 8; j++) begin
      spiMaster = j[0]; spiMosiOut = j[1]; spiSckOut = j[2]; spiMisoOut = ~j[1]; tick();
    end

    // R7 / R8: compare channels
    curReq = "R7";
    busWrite(2'd1, 8'hF0);
    busWrite(2'd2, 8'hA0);
    cmpEn = 4'hF;
    for (int j = 0; j < 16; j++) begin cmpVal = j[3:0]; tick(); end
    busWrite(2'd1, 8'h50);
    for (int j = 0; j < 4; j++) begin cmpVal = ~j[3:0]; tick(); end
    curReq = "R8";
    busWrite(2'd1, 8'hF0);
    cmpEn = 4'h0; cmpVal = 4'hF; tick();
    cmpEn = 4'h5; tick();

    // R9: pin read lag
    curReq = "R9";
    busAddr = 2'd0;
    for (int j = 0; j < 12; j++) begin padIn = 8'h11 * j[7:0] ^ 8'h3C; tick(); end

    // mixed random traffic across all rules
    curReq = "MIX";
    for (int j = 0; j < 3000; j++) begin
      busAddr = $urandom_range(0, 3);
      busWrEn = ($urandom_range(0, 3) == 0);
      busWrData = $urandom;
      spiEn = $urandom; spiMaster = $urandom;
      spiMosiOut = $urandom; spiSckOut = $urandom; spiMisoOut = $urandom;
      cmpEn = $urandom; cmpVal = $urandom; padIn = $urandom;
      tick();
    end
    busWrEn = 1'b0;
    tick();
    finish();
  end

endmodule